// File: doc/BRIEF.md
# Floating-Point Control State and Context Tracker

This block keeps the architectural control state of a single-precision floating-point unit in a RISC-V core. It holds the sticky exception flags and the dynamic rounding mode. Software sees them through three CSR views: flags alone, rounding mode alone, and a combined register that aliases both. The FPU reports exception flags when an instruction retires, and the block ORs them into the sticky set.

The block also owns the floating-point context status field of the machine status register and the summary bit derived from it. After reset the field is Off. In that state any floating-point instruction or FP CSR access named by the decoder is flagged as illegal, and the access has no effect. Once software enables the unit, every retired change to floating-point state marks the context Dirty. A context switch routine can then save the FP registers only when they have really changed.

A small rounding-mode resolver sits beside the stored mode. It turns an instruction's rounding field into the effective mode and tells the issue logic whether that mode is legal.

Top module: `fpcsr_state_unit`

## Requirements
- R1: After reset the flags are 0, the stored rounding mode is 0, the context status is Off (0) and the summary bit is 0.
- R2: CSR address 0x001 reads the flags in bits 4:0. Address 0x002 reads the rounding mode in bits 2:0. Address 0x003 reads the flags in bits 4:0 and the rounding mode in bits 7:5. All other bits read 0. `csr_hit` is 1 only for these three addresses. Read data is 0 when no valid, legal FP CSR access is present.
- R3: A write through any of the three views updates the shared storage, so the other views reflect it in the next cycle. A write to 0x001 leaves the rounding mode unchanged, and a write to 0x002 leaves the flags unchanged.
- R4: When the FPU reports flags, they are ORed into the stored flags and never clear a flag. If a CSR write to the flags lands in the same cycle, the written value is applied first and the reported flags are ORed into it.
- R5: While the status is Off, `illegal_o` is 1 whenever `dec_fp_access` is 1 or a valid access targets an FP CSR, and such CSR writes change nothing. In every other status `illegal_o` is 0.
- R6: A machine status write loads the context status from `ms_wdata` bits 14:13 (Off=0, Initial=1, Clean=2, Dirty=3). `mstatus_fp_o` shows the status at bits 14:13 and the summary bit at bit 31, with all other bits 0.
- R7: `sd_o` is 1 exactly when the status is Dirty (3).
- R8: When the status is not Off, the status becomes Dirty in the next cycle after any of these events: an applied FP CSR write, an FPU flag report, or an FP register write retiring. A machine status write in the same cycle takes priority over this.
- R9: The effective rounding mode is `instr_rm`, except when `instr_rm` is 7, where it is the stored mode. `rm_bad_o` is 1 when the effective mode is 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_valid | input | 1 | CSR access present this cycle |
| csr_we | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data |
| csr_hit | output | 1 | Address selects one of the FP CSR views |
| fpu_fl_valid | input | 1 | FPU reports exception flags at retirement |
| fpu_fl | input | 5 | Reported exception flags |
| fpreg_wr | input | 1 | An FP register write retires |
| dec_fp_access | input | 1 | Decoder: instruction touches FP state |
| illegal_o | output | 1 | FP access while the unit is Off |
| ms_we | input | 1 | Machine status register write |
| ms_wdata | input | 32 | Machine status write data |
| mstatus_fp_o | output | 32 | FP-owned bits of the machine status register |
| fs_o | output | 2 | Context status |
| sd_o | output | 1 | Summary dirty bit |
| instr_rm | input | 3 | Rounding field of the instruction at issue |
| rm_eff_o | output | 3 | Effective rounding mode |
| rm_bad_o | output | 1 | Effective rounding mode is illegal |

## Verification
The bench builds the block with its default parameters: 5 flag bits, 3 rounding bits, a 32-bit data path, CSR addresses 0x001 to 0x003, and the status field at bit 13. With these values every flag pattern and every rounding code can be reached. The bench drives the decoder query in all four status values. It also drives the overlap of a CSR write with a flag report, and a machine status write that lands together with a dirtying event.

// File: rtl/fpcsr_pkg.sv
// Shared types for the floating-point control state block.
// Assumes the conventional two-bit context status encoding.
package fpcsr_pkg;
    typedef enum logic [1:0] {
        FS_OFF   = 2'd0,
        FS_INIT  = 2'd1,
        FS_CLEAN = 2'd2,
        FS_DIRTY = 2'd3
    } fs_e;
endpackage

// File: rtl/fpcsr_flag_acc.sv
// Sticky exception flag storage.
// A write value replaces the stored flags, and retiring flags are ORed on top.
// Assumes that the caller has already gated the enables for legality.
module fpcsr_flag_acc #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         acc_en,
    input  logic [W-1:0] acc_val,
    output logic [W-1:0] q
);
    logic [W-1:0] base;
    logic [W-1:0] add;

    // choose the write value or the held value as the base
    always_comb base = wr_en ? wr_val : q;

    // mask the retiring flags
    always_comb add = acc_en ? acc_val : '0;

    // register the merged sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= base | add;
    end
endmodule

// File: rtl/fpcsr_rmode.sv
// Dynamic rounding mode storage and effective mode resolver.
// The all-ones instruction code selects the stored mode.
// Codes above MAX_OK are illegal.
module fpcsr_rmode #(
    parameter int W      = 3,
    parameter int MAX_OK = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] instr_rm,
    output logic [W-1:0] q,
    output logic [W-1:0] eff,
    output logic         bad
);
    localparam logic [W-1:0] DYN = '1;

    // hold the software-written mode
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_val;
    end

    // resolve the dynamic selection
    always_comb eff = (instr_rm == DYN) ? q : instr_rm;

    // flag the reserved and unresolvable codes
    always_comb bad = (int'(eff) > MAX_OK);
endmodule

// File: rtl/fpcsr_ctx_status.sv
// Context status tracker.
// A software write sets the status directly. A dirtying event moves a
// non-Off status to Dirty. The software write wins when both occur.
module fpcsr_ctx_status
    import fpcsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_we,
    input  fs_e  sw_val,
    input  logic dirty_ev,
    output fs_e  fs_q,
    output logic off,
    output logic sd
);
    // update the status
    always_ff @(posedge clk) begin
        if (!rst_n)                         fs_q <= FS_OFF;
        else if (sw_we)                     fs_q <= sw_val;
        else if (dirty_ev && fs_q != FS_OFF) fs_q <= FS_DIRTY;
    end

    // decode the Off and summary conditions
    always_comb begin
        off = (fs_q == FS_OFF);
        sd  = (fs_q == FS_DIRTY);
    end
endmodule

// File: rtl/fpcsr_state_unit.sv
// Floating-point control/status state.
// Holds the sticky flags and the rounding mode behind three CSR views.
// Tracks the context status and the summary bit, and reports illegal FP
// access while the unit is Off. CSR reads are combinational.
module fpcsr_state_unit
    import fpcsr_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          ADDR_W     = 12,
    parameter int          FLAG_W     = 5,
    parameter int          RM_W       = 3,
    parameter int          RM_MAX_OK  = 4,
    parameter int          FS_LSB     = 13,
    parameter logic [11:0] A_FLAGS    = 12'h001,
    parameter logic [11:0] A_RMODE    = 12'h002,
    parameter logic [11:0] A_COMBINED = 12'h003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_valid,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_hit,
    input  logic              fpu_fl_valid,
    input  logic [FLAG_W-1:0] fpu_fl,
    input  logic              fpreg_wr,
    input  logic              dec_fp_access,
    output logic              illegal_o,
    input  logic              ms_we,
    input  logic [XLEN-1:0]   ms_wdata,
    output logic [XLEN-1:0]   mstatus_fp_o,
    output logic [1:0]        fs_o,
    output logic              sd_o,
    input  logic [RM_W-1:0]   instr_rm,
    output logic [RM_W-1:0]   rm_eff_o,
    output logic              rm_bad_o
);
    localparam int SD_BIT  = XLEN - 1;
    localparam int CMB_W   = FLAG_W + RM_W;
    localparam int NVIEW   = 3;

    logic [NVIEW-1:0]  sel;
    logic              off, sd;
    fs_e               fs_q;
    logic              acc_ok, wr_ok;
    logic              wr_flags, wr_rmode;
    logic [FLAG_W-1:0] flag_wval, flags_q;
    logic [RM_W-1:0]   rm_wval, rm_q;
    logic              dirty_ev;
    logic [CMB_W-1:0]  view_val;
    logic              unused_bits;

    localparam logic [ADDR_W-1:0] VADDR [NVIEW] = '{
        ADDR_W'(A_FLAGS), ADDR_W'(A_RMODE), ADDR_W'(A_COMBINED)};

    // one address comparator per view
    for (genvar v = 0; v < NVIEW; v++) begin : g_view
        assign sel[v] = (csr_addr == VADDR[v]);
    end

    // address decode and access legality
    always_comb begin
        csr_hit   = |sel;
        acc_ok    = csr_valid && csr_hit && !off;
        wr_ok     = acc_ok && csr_we;
        illegal_o = off && (dec_fp_access || (csr_valid && csr_hit));
    end

    // route write data to the field owners
    always_comb begin
        wr_flags  = wr_ok && (sel[0] || sel[2]);
        wr_rmode  = wr_ok && (sel[1] || sel[2]);
        flag_wval = csr_wdata[FLAG_W-1:0];
        rm_wval   = sel[2] ? csr_wdata[CMB_W-1:FLAG_W] : csr_wdata[RM_W-1:0];
    end

    // collect the events that change floating-point state
    always_comb dirty_ev = wr_ok || fpu_fl_valid || fpreg_wr;

    fpcsr_flag_acc #(.W(FLAG_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_flags),
        .wr_val  (flag_wval),
        .acc_en  (fpu_fl_valid),
        .acc_val (fpu_fl),
        .q       (flags_q)
    );

    fpcsr_rmode #(.W(RM_W), .MAX_OK(RM_MAX_OK)) u_rmode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_rmode),
        .wr_val   (rm_wval),
        .instr_rm (instr_rm),
        .q        (rm_q),
        .eff      (rm_eff_o),
        .bad      (rm_bad_o)
    );

    fpcsr_ctx_status u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (ms_we),
        .sw_val   (fs_e'(ms_wdata[FS_LSB+1:FS_LSB])),
        .dirty_ev (dirty_ev),
        .fs_q     (fs_q),
        .off      (off),
        .sd       (sd)
    );

    // build the combined view and the read mux
    always_comb begin
        view_val  = {rm_q, flags_q};
        csr_rdata = '0;
        if (acc_ok) begin
            if (sel[0]) csr_rdata[FLAG_W-1:0] = flags_q;
            if (sel[1]) csr_rdata[RM_W-1:0]   = rm_q;
            if (sel[2]) csr_rdata[CMB_W-1:0]  = view_val;
        end
    end

    // drive the machine status bits owned here
    always_comb begin
        mstatus_fp_o                    = '0;
        mstatus_fp_o[FS_LSB+1:FS_LSB]   = fs_q;
        mstatus_fp_o[SD_BIT]            = sd;
        fs_o                            = fs_q;
        sd_o                            = sd;
    end

    // mark the data bits that this block does not consume
    assign unused_bits = ^{csr_wdata, ms_wdata};
endmodule

// File: rtl/fpcsr_state_unit_chk.sv
// Property checker for fpcsr_state_unit, attached with bind.
module fpcsr_state_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] fs_o,
    input logic       sd_o,
    input logic       illegal_o,
    input logic [2:0] rm_eff_o,
    input logic       rm_bad_o,
    input logic       fpu_fl_valid,
    input logic [4:0] fpu_fl,
    input logic [4:0] flags_q,
    input logic       ms_we,
    input logic       csr_valid,
    input logic       csr_we
);
    p_flags_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fpu_fl_valid |=> ((flags_q & $past(fpu_fl)) == $past(fpu_fl)));

    p_off_blocks_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_o == 2'd0 && csr_valid && csr_we && !fpu_fl_valid) |=> $stable(flags_q));

    p_illegal_only_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> fs_o == 2'd0);

    p_sd_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sd_o == (fs_o == 2'd3));

    p_report_dirties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_o != 2'd0 && fpu_fl_valid && !ms_we) |=> fs_o == 2'd3);

    p_bad_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rm_bad_o |-> rm_eff_o > 3'd4);
endmodule

bind fpcsr_state_unit fpcsr_state_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fs_o         (fs_o),
    .sd_o         (sd_o),
    .illegal_o    (illegal_o),
    .rm_eff_o     (rm_eff_o),
    .rm_bad_o     (rm_bad_o),
    .fpu_fl_valid (fpu_fl_valid),
    .fpu_fl       (fpu_fl),
    .flags_q      (flags_q),
    .ms_we        (ms_we),
    .csr_valid    (csr_valid),
    .csr_we       (csr_we)
);

// File: tb/fpcsr_state_unit_tb.sv
module fpcsr_state_unit_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        csr_valid = 0, csr_we = 0;
    logic [11:0] csr_addr = 0;
    logic [31:0] csr_wdata = 0, csr_rdata;
    logic        csr_hit;
    logic        fpu_fl_valid = 0;
    logic [4:0]  fpu_fl = 0;
    logic        fpreg_wr = 0, dec_fp_access = 0, illegal_o;
    logic        ms_we = 0;
    logic [31:0] ms_wdata = 0, mstatus_fp_o;
    logic [1:0]  fs_o;
    logic        sd_o;
    logic [2:0]  instr_rm = 0, rm_eff_o;
    logic        rm_bad_o;

    int total = 0, bad = 0;
    bit done = 0;
    int m_fs = 0, m_fl = 0, m_rm = 0;

    always #5 clk = ~clk;

    fpcsr_state_unit u_dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // reference model, combinational outputs checked every cycle
    task automatic compare_all();
        int hit, eff, rd;
        hit = (csr_addr >= 1 && csr_addr <= 3) ? 1 : 0;
        rd = 0;
        if (csr_valid && hit == 1 && m_fs != 0)
            rd = (csr_addr == 1) ? m_fl : (csr_addr == 2) ? m_rm : (m_rm * 32 + m_fl);
        eff = (instr_rm == 7) ? m_rm : int'(instr_rm);
        chk("R2 hit", 32'(csr_hit), 32'(hit));
        chk("R2 rdata", csr_rdata, 32'(rd));
        chk("R5 illegal", 32'(illegal_o),
            32'(m_fs == 0 && (dec_fp_access || (csr_valid && hit == 1))));
        chk("R8 fs", 32'(fs_o), 32'(m_fs));
        chk("R7 sd", 32'(sd_o), 32'(m_fs == 3));
        chk("R6 mstatus", mstatus_fp_o, (32'(m_fs == 3) << 31) | (32'(m_fs) << 13));
        chk("R9 eff", 32'(rm_eff_o), 32'(eff));
        chk("R9 bad", 32'(rm_bad_o), 32'(eff >= 5));
    endtask

    task automatic model_step();
        int hit, nf, nr;
        bit wen;
        hit = (csr_addr >= 1 && csr_addr <= 3) ? 1 : 0;
        wen = csr_valid && csr_we && hit == 1 && m_fs != 0;
        nf = m_fl; nr = m_rm;
        if (wen && (csr_addr == 1 || csr_addr == 3)) nf = csr_wdata[4:0];
        if (wen && csr_addr == 2) nr = csr_wdata[2:0];
        if (wen && csr_addr == 3) nr = csr_wdata[7:5];
        if (fpu_fl_valid) nf = nf | fpu_fl;
        if (ms_we) m_fs = ms_wdata[14:13];
        else if (m_fs != 0 && (wen || fpu_fl_valid || fpreg_wr)) m_fs = 3;
        m_fl = nf; m_rm = nr;
    endtask

    task automatic cyc();
        #1 compare_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
        csr_valid = 0; csr_we = 0; fpu_fl_valid = 0; fpreg_wr = 0;
        dec_fp_access = 0; ms_we = 0;
    endtask

    task automatic csr(bit we, logic [11:0] a, logic [31:0] d);
        csr_valid = 1; csr_we = we; csr_addr = a; csr_wdata = d;
    endtask

    task automatic set_fs(int v);
        ms_we = 1; ms_wdata = 32'(v) << 13; cyc();
    endtask

    task automatic read_chk(string req, logic [11:0] a, logic [31:0] exp);
        csr(0, a, 0);
        #1 chk(req, csr_rdata, exp);
        cyc();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 fs", 32'(fs_o), 0);
        chk("R1 sd", 32'(sd_o), 0);
        chk("R1 eff", 32'(rm_eff_o), 0);
        instr_rm = 7;
        cyc();
        instr_rm = 0;
        // R5: while Off, decoder query and CSR write are illegal; write dropped
        dec_fp_access = 1; cyc();
        csr(1, 12'h003, 32'hFF); cyc();
        fpreg_wr = 1; cyc();
        set_fs(1);
        read_chk("R5 dropped write", 12'h003, 0);
        // illegal never outside Off
        for (int s = 1; s < 4; s++) begin
            set_fs(s);
            dec_fp_access = 1; csr(0, 12'h001, 0); cyc();
        end
        // R3: alias consistency
        set_fs(1);
        csr(1, 12'h003, 32'hFFFF_FF6A); cyc();   // flags 0x0A, rm 3
        read_chk("R3 flags view", 12'h001, 32'h0A);
        read_chk("R3 rmode view", 12'h002, 32'h3);
        csr(1, 12'h002, 32'h4); cyc();
        read_chk("R3 combined after rm", 12'h003, 32'h8A);
        csr(1, 12'h001, 32'h15); cyc();
        read_chk("R3 combined after flags", 12'h003, 32'h95);
        // R4: sticky accrual and overlap with write
        csr(1, 12'h001, 0); cyc();
        fpu_fl_valid = 1; fpu_fl = 5'h01; cyc();
        fpu_fl_valid = 1; fpu_fl = 5'h10; cyc();
        read_chk("R4 sticky", 12'h001, 32'h11);
        csr(1, 12'h001, 32'h02); fpu_fl_valid = 1; fpu_fl = 5'h04; cyc();
        read_chk("R4 write then or", 12'h001, 32'h06);
        // R8: dirtying events and priority
        set_fs(2); fpu_fl_valid = 1; fpu_fl = 0; cyc();
        set_fs(2); fpreg_wr = 1; cyc();
        set_fs(1); csr(0, 12'h001, 0); cyc();
        set_fs(2); fpreg_wr = 1; ms_we = 1; ms_wdata = 32'(2) << 13; cyc();
        set_fs(0); fpreg_wr = 1; fpu_fl_valid = 1; fpu_fl = 5'h08; cyc();
        csr(0, 12'h005, 0); cyc();
        // R9: all instruction codes under each stored mode
        set_fs(1);
        for (int r = 0; r < 8; r++) begin
            csr(1, 12'h002, 32'(r)); cyc();
            for (int i = 0; i < 8; i++) begin
                instr_rm = 3'(i); cyc();
            end
        end
        set_fs(3);
        csr(0, 12'h7C0, 0); cyc();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule